// File: doc/BRIEF.md
# Bus-Synchronised Sampling Trigger Controller

Many acquisition nodes share one half-duplex serial line. This block lets all of them take a sample in the same instant, and it needs no separate trigger wire. One node is made master by a configuration byte. Its timer paces the run, and on every period it asks the line transmitter to send one escape byte. Every node watches the line, the master through its own echo, and fires a sample strobe on the falling edge that opens that byte. The falling edge reaches all nodes at nearly the same moment, so the strobes are aligned to within one synchroniser delay.

Before a run, software arms the node. Sampling starts only after a run of five start symbols is received. Ordinary packets never contain that run, so sampling cannot begin by accident. In sampling mode the block withholds received bytes from the packet path. It counts strobes against a programmed total and marks the first strobe as discard, because the converter still returns the previous result at that point. When the total is reached, it returns to packet mode and pulses a done flag.

Top module: `sync_sample_trigger`

## Requirements
- R1: Writing cookie byte 8'hAA makes the node master (is_master_o=1). Writing any other byte makes it a slave.
- R2: In the armed state the node enters sampling mode (sampling_o=1) once it has received five consecutive start symbols 8'h0F. Any other byte resets the run, so a run of four never enters sampling. Line framing is 8 data bits, LSB first, one start bit (low) and one stop bit (high), CLKS_PER_BIT clocks per bit.
- R3: While sampling, a master's timer counts up from reload_i and overflows every 2^16-reload_i clocks. Each overflow raises tx_req_o for one cycle with tx_byte_o=8'h10. No more than total_i requests are made per run.
- R4: In sampling mode every node, master included, pulses strobe_o once on the falling edge of a received byte's start bit.
- R5: After a strobe, further falling edges are ignored until that byte's stop bit has been sampled. Data bits therefore never add strobes, and each trigger byte gives exactly one strobe.
- R6: Strobes are counted against the 24-bit total_i captured at arm. After the stop bit of the byte that carried the total-th strobe, the node leaves sampling mode and pulses done_o for one cycle. Later bytes produce no strobe.
- R7: store_o is 0 on the first strobe of a run and 1 on every later strobe.
- R8: A byte received outside sampling mode appears once on pkt_vld_o/pkt_byte_o. A byte received in sampling mode, including the escape byte 8'h10, never appears there.
- R9: If busy_i is high at strobe time, overrun_o is set. It stays set until the next arm.
- R10: After reset the outputs strobe_o, done_o, tx_req_o, pkt_vld_o, overrun_o, sampling_o and is_master_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Shared serial line, idle high |
| cookie_we_i | input | 1 | Strobe to write the cookie byte |
| cookie_byte_i | input | 8 | Cookie byte; 8'hAA selects master |
| arm_i | input | 1 | Arm request, taken in packet mode |
| reload_i | input | TMR_W | Timer reload value |
| total_i | input | CNT_W | Strobes per run, captured at arm |
| busy_i | input | 1 | Converter busy at strobe time |
| tx_req_o | output | 1 | One-cycle request to transmit a byte |
| tx_byte_o | output | 8 | Byte to transmit (escape 8'h10) |
| strobe_o | output | 1 | Sample strobe pulse |
| store_o | output | 1 | Qualifies strobe: 1 store, 0 discard |
| done_o | output | 1 | One-cycle pulse at end of run |
| overrun_o | output | 1 | Sticky busy-at-strobe flag |
| sampling_o | output | 1 | Node is in sampling mode |
| is_master_o | output | 1 | Node holds the cookie |
| pkt_vld_o | output | 1 | Packet byte valid |
| pkt_byte_o | output | 8 | Packet byte |

## Verification
The hardest case to reach is a stray edge inside a trigger byte. The escape byte 8'h10 has a high-to-low transition between data bits 4 and 5, so every trigger byte the bench sends makes that edge, and the strobe scoreboard rejects any extra strobe. The master run is hard to reach as well, because it needs a closed loop. The bench acts as the line transmitter: it answers each tx_req_o by serialising tx_byte_o back onto rx_i, and it times the gap between requests. Near-miss start-symbol runs, with a foreign byte inside a run and a run of four, are sent before the real run of five.

// File: rtl/trig_pkg.sv
package trig_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_SAMPLING} seq_state_e;
   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
   localparam logic [7:0] START_SYM  = 8'h0F;
   localparam logic [7:0] ESC_SYM    = 8'h10;
   localparam logic [7:0] MASTER_KEY = 8'hAA;
endpackage

// File: rtl/trig_rx_framer.sv
module trig_rx_framer
   import trig_pkg::*;
#(
   parameter int CLKS_PER_BIT = 16,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_i,
   output logic       line_fell_o,
   output logic       frame_end_o,
   output logic       byte_vld_o,
   output logic [7:0] byte_o
);
   localparam int CW   = $clog2(CLKS_PER_BIT);
   localparam int HALF = CLKS_PER_BIT / 2;

   if (CLKS_PER_BIT < 4) begin : g_bad_cpb
      $error("CLKS_PER_BIT must be at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[s] <= 1'b1;
         else if (s == 0) sync_q[s] <= rx_i;
         else sync_q[s] <= sync_q[(s > 0) ? s - 1 : 0];
      end
   end

   logic      line_s, prev_q;
   rx_state_e st_q;
   logic [CW-1:0] cnt_q;
   logic [2:0] bit_q;
   logic [7:0] sh_q;
   logic       fe_q, vld_q;

   assign line_s      = sync_q[SYNC_STAGES-1];
   assign line_fell_o = prev_q & ~line_s;
   assign frame_end_o = fe_q;
   assign byte_vld_o  = vld_q;
   assign byte_o      = sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         st_q   <= RX_IDLE;
         cnt_q  <= '0;
         bit_q  <= '0;
         sh_q   <= '0;
         fe_q   <= 1'b0;
         vld_q  <= 1'b0;
      end else begin
         prev_q <= line_s;
         fe_q   <= 1'b0;
         vld_q  <= 1'b0;
         case (st_q)
            RX_IDLE: if (line_fell_o) begin
               st_q  <= RX_START;
               cnt_q <= '0;
            end
            RX_START: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CW'(HALF - 1)) begin
                  cnt_q <= '0;
                  bit_q <= '0;
                  st_q  <= line_s ? RX_IDLE : RX_DATA;
               end
            end
            RX_DATA: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CW'(CLKS_PER_BIT - 1)) begin
                  cnt_q <= '0;
                  sh_q  <= {line_s, sh_q[7:1]};
                  bit_q <= bit_q + 1'b1;
                  if (bit_q == 3'd7) st_q <= RX_STOP;
               end
            end
            default: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CW'(CLKS_PER_BIT - 1)) begin
                  cnt_q <= '0;
                  fe_q  <= 1'b1;
                  vld_q <= line_s;
                  st_q  <= RX_IDLE;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/trig_period_timer.sv
module trig_period_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic         en_i,
   input  logic [W-1:0] reload_i,
   output logic         tick_o
);
   if (W < 2) begin : g_bad_w
      $error("timer width must be at least 2");
   end

   logic [W-1:0] cnt_q;
   logic         tick_q;
   assign tick_o = tick_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else begin
         tick_q <= 1'b0;
         if (load_i) begin
            cnt_q <= reload_i;
         end else if (en_i) begin
            if (&cnt_q) begin
               cnt_q  <= reload_i;
               tick_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/trig_sample_seq.sv
module trig_sample_seq
   import trig_pkg::*;
#(
   parameter int CNT_W   = 24,
   parameter int RUN_LEN = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic [CNT_W-1:0] total_i,
   input  logic             line_fell_i,
   input  logic             frame_end_i,
   input  logic             byte_vld_i,
   input  logic [7:0]       byte_i,
   input  logic             master_i,
   input  logic             tick_i,
   input  logic             busy_i,
   output logic             sampling_o,
   output logic             tmr_load_o,
   output logic             strobe_o,
   output logic             store_o,
   output logic             done_o,
   output logic             overrun_o,
   output logic             tx_req_o,
   output logic             pkt_vld_o,
   output logic [7:0]       pkt_byte_o
);
   localparam int RW = $clog2(RUN_LEN + 1);

   if (RUN_LEN < 3) begin : g_bad_run
      $error("RUN_LEN must exceed the two start symbols a packet may hold");
   end

   seq_state_e       st_q;
   logic [RW-1:0]    run_q;
   logic [CNT_W-1:0] total_q, smp_q, txc_q;
   logic             edge_en_q, strobe_q, store_q, done_q, ovr_q;
   logic             load_q, txr_q, pkt_q;
   logic [7:0]       pb_q;

   assign sampling_o = (st_q == ST_SAMPLING);
   assign tmr_load_o = load_q;
   assign strobe_o   = strobe_q;
   assign store_o    = store_q;
   assign done_o     = done_q;
   assign overrun_o  = ovr_q;
   assign tx_req_o   = txr_q;
   assign pkt_vld_o  = pkt_q;
   assign pkt_byte_o = pb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;  run_q <= '0;
         total_q <= '0;    smp_q <= '0;   txc_q <= '0;
         edge_en_q <= 1'b0; strobe_q <= 1'b0; store_q <= 1'b0;
         done_q <= 1'b0;   ovr_q <= 1'b0;  load_q <= 1'b0;
         txr_q <= 1'b0;    pkt_q <= 1'b0;  pb_q <= '0;
      end else begin
         strobe_q <= 1'b0;
         done_q   <= 1'b0;
         load_q   <= 1'b0;
         txr_q    <= 1'b0;
         pkt_q    <= byte_vld_i && (st_q != ST_SAMPLING);
         if (byte_vld_i) pb_q <= byte_i;
         if (tick_i && master_i && st_q == ST_SAMPLING && txc_q < total_q) begin
            txr_q <= 1'b1;
            txc_q <= txc_q + 1'b1;
         end
         case (st_q)
            ST_IDLE: if (arm_i) begin
               st_q    <= ST_ARMED;
               total_q <= total_i;
               run_q   <= '0;
               smp_q   <= '0;
               txc_q   <= '0;
               ovr_q   <= 1'b0;
            end
            ST_ARMED: if (byte_vld_i) begin
               if (byte_i == START_SYM) begin
                  if (run_q == RW'(RUN_LEN - 1)) begin
                     st_q      <= ST_SAMPLING;
                     load_q    <= 1'b1;
                     edge_en_q <= 1'b1;
                  end else begin
                     run_q <= run_q + 1'b1;
                  end
               end else begin
                  run_q <= '0;
               end
            end
            default: begin
               if (line_fell_i && edge_en_q) begin
                  strobe_q  <= 1'b1;
                  store_q   <= (smp_q != '0);
                  smp_q     <= smp_q + 1'b1;
                  edge_en_q <= 1'b0;
                  if (busy_i) ovr_q <= 1'b1;
               end
               if (frame_end_i) begin
                  edge_en_q <= 1'b1;
                  if (smp_q >= total_q) begin
                     st_q   <= ST_IDLE;
                     done_q <= 1'b1;
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/sync_sample_trigger.sv
module sync_sample_trigger
   import trig_pkg::*;
#(
   parameter int CLKS_PER_BIT = 16,
   parameter int SYNC_STAGES  = 2,
   parameter int TMR_W        = 16,
   parameter int CNT_W        = 24,
   parameter int RUN_LEN      = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_i,
   input  logic             cookie_we_i,
   input  logic [7:0]       cookie_byte_i,
   input  logic             arm_i,
   input  logic [TMR_W-1:0] reload_i,
   input  logic [CNT_W-1:0] total_i,
   input  logic             busy_i,
   output logic             tx_req_o,
   output logic [7:0]       tx_byte_o,
   output logic             strobe_o,
   output logic             store_o,
   output logic             done_o,
   output logic             overrun_o,
   output logic             sampling_o,
   output logic             is_master_o,
   output logic             pkt_vld_o,
   output logic [7:0]       pkt_byte_o
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   logic       fell, fend, bvld, tick, tload, master_q;
   logic [7:0] rbyte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) master_q <= 1'b0;
      else if (cookie_we_i) master_q <= (cookie_byte_i == MASTER_KEY);
   end
   assign is_master_o = master_q;
   assign tx_byte_o   = ESC_SYM;

   trig_rx_framer #(.CLKS_PER_BIT(CLKS_PER_BIT), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .line_fell_o(fell),
      .frame_end_o(fend), .byte_vld_o(bvld), .byte_o(rbyte));

   trig_period_timer #(.W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load_i(tload),
      .en_i(sampling_o && master_q), .reload_i(reload_i), .tick_o(tick));

   trig_sample_seq #(.CNT_W(CNT_W), .RUN_LEN(RUN_LEN)) u_seq (
      .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .total_i(total_i),
      .line_fell_i(fell), .frame_end_i(fend), .byte_vld_i(bvld), .byte_i(rbyte),
      .master_i(master_q), .tick_i(tick), .busy_i(busy_i),
      .sampling_o(sampling_o), .tmr_load_o(tload), .strobe_o(strobe_o),
      .store_o(store_o), .done_o(done_o), .overrun_o(overrun_o),
      .tx_req_o(tx_req_o), .pkt_vld_o(pkt_vld_o), .pkt_byte_o(pkt_byte_o));
endmodule

// File: rtl/sync_sample_trigger_chk.sv
module sync_sample_trigger_chk (
   input logic clk,
   input logic rst_n,
   input logic arm_i,
   input logic strobe_o,
   input logic sampling_o,
   input logic done_o,
   input logic overrun_o,
   input logic tx_req_o,
   input logic is_master_o,
   input logic pkt_vld_o
);
   // R4
   strobe_in_sampling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> $past(sampling_o));
   // R5
   single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |=> !strobe_o);
   // R6
   done_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!sampling_o && $past(sampling_o)));
   // R3
   tx_only_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req_o |-> (is_master_o && $past(sampling_o)));
   // R8
   no_pkt_sampling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sampling_o && $past(sampling_o)) |-> !pkt_vld_o);
   // R9
   overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun_o) |-> strobe_o);
   // R9
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(overrun_o) |-> $past(arm_i));
endmodule

bind sync_sample_trigger sync_sample_trigger_chk u_chk (.*);

// File: tb/sync_sample_trigger_tb.sv
module sync_sample_trigger_tb;
   localparam int CPB = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx = 1'b1;
   logic        cookie_we = 1'b0;
   logic [7:0]  cookie_byte = 8'h00;
   logic        arm = 1'b0;
   logic [15:0] reload = 16'hFF9C;
   logic [23:0] total = 24'd0;
   logic        busy = 1'b0;
   logic        tx_req_o, strobe_o, store_o, done_o, overrun_o;
   logic        sampling_o, is_master_o, pkt_vld_o;
   logic [7:0]  tx_byte_o, pkt_byte_o;

   int checks = 0, fails = 0, mon_checks = 0, mon_fails = 0;
   int done_cnt = 0, cyc = 0;
   bit exp_store[$];
   logic [7:0] exp_pkt[$];
   int tx_times[$];

   always #2.5 clk = ~clk;

   sync_sample_trigger #(.CLKS_PER_BIT(CPB)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .cookie_we_i(cookie_we),
      .cookie_byte_i(cookie_byte), .arm_i(arm), .reload_i(reload),
      .total_i(total), .busy_i(busy), .tx_req_o(tx_req_o), .tx_byte_o(tx_byte_o),
      .strobe_o(strobe_o), .store_o(store_o), .done_o(done_o),
      .overrun_o(overrun_o), .sampling_o(sampling_o), .is_master_o(is_master_o),
      .pkt_vld_o(pkt_vld_o), .pkt_byte_o(pkt_byte_o));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input bit as_pkt);
      if (as_pkt) exp_pkt.push_back(b);
      @(negedge clk);
      rx = 1'b0;
      repeat (CPB) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rx = b[i];
         repeat (CPB) @(negedge clk);
      end
      rx = 1'b1;
      repeat (4 * CPB) @(negedge clk);
   endtask

   task automatic do_arm(input logic [23:0] n);
      @(negedge clk);
      total = n; arm = 1'b1;
      @(negedge clk);
      arm = 1'b0;
   endtask

   task automatic set_cookie(input logic [7:0] b);
      @(negedge clk);
      cookie_byte = b; cookie_we = 1'b1;
      @(negedge clk);
      cookie_we = 1'b0;
      @(negedge clk);
   endtask

   // monitor: pops scoreboard queues as results appear
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n) begin
            if (strobe_o) begin
               mon_checks++;
               if (exp_store.size() == 0) begin
                  mon_fails++;
                  $display("FAIL R5 extra strobe actual=1 expected=0");
               end else begin
                  bit e;
                  e = exp_store.pop_front();
                  if (store_o !== e) begin
                     mon_fails++;
                     $display("FAIL R7 store flag actual=%0d expected=%0d", store_o, e);
                  end
               end
            end
            if (pkt_vld_o) begin
               mon_checks++;
               if (exp_pkt.size() == 0) begin
                  mon_fails++;
                  $display("FAIL R8 unexpected packet byte actual=%0h expected=none", pkt_byte_o);
               end else begin
                  logic [7:0] p;
                  p = exp_pkt.pop_front();
                  if (pkt_byte_o !== p) begin
                     mon_fails++;
                     $display("FAIL R8 packet byte actual=%0h expected=%0h", pkt_byte_o, p);
                  end
               end
            end
            if (done_o) done_cnt++;
            if (tx_req_o) tx_times.push_back(cyc);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks + mon_checks + 1, fails + mon_fails + 1);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R10 reset state
      chk(!strobe_o && !done_o && !tx_req_o && !pkt_vld_o, "R10 pulses low", int'(strobe_o), 0);
      chk(!overrun_o && !sampling_o && !is_master_o, "R10 flags low", int'(sampling_o), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 slave cookie
      set_cookie(8'h55);
      chk(is_master_o == 1'b0, "R1 cookie 55 is slave", int'(is_master_o), 0);

      // R8 packet mode passes escape and start bytes, no strobe
      send_byte(8'h10, 1'b1);
      send_byte(8'h0F, 1'b1);
      chk(sampling_o == 1'b0, "R2 idle stays in packet mode", int'(sampling_o), 0);

      // R2 near-miss runs never start sampling
      do_arm(24'd3);
      send_byte(8'h0F, 1); send_byte(8'h0F, 1); send_byte(8'h22, 1);
      send_byte(8'h0F, 1); send_byte(8'h0F, 1); send_byte(8'h0F, 1);
      send_byte(8'h0F, 1); send_byte(8'h44, 1);
      chk(sampling_o == 1'b0, "R2 run of four ignored", int'(sampling_o), 0);
      send_byte(8'h10, 1'b1);
      chk(sampling_o == 1'b0, "R2 escape while armed", int'(sampling_o), 0);
      for (int k = 0; k < 5; k++) send_byte(8'h0F, 1'b1);
      chk(sampling_o == 1'b1, "R2 five start symbols", int'(sampling_o), 1);

      // R4 R5 R7 slave run of three
      exp_store.push_back(1'b0); exp_store.push_back(1'b1); exp_store.push_back(1'b1);
      send_byte(8'h10, 1'b0);
      send_byte(8'h10, 1'b0);
      chk(sampling_o == 1'b1, "R6 still sampling before total", int'(sampling_o), 1);
      send_byte(8'h10, 1'b0);
      chk(sampling_o == 1'b0, "R6 back to packet mode", int'(sampling_o), 0);
      chk(done_cnt == 1, "R6 one done pulse", done_cnt, 1);
      chk(exp_store.size() == 0, "R4 all strobes seen", exp_store.size(), 0);
      chk(overrun_o == 1'b0, "R9 no overrun without busy", int'(overrun_o), 0);
      send_byte(8'h10, 1'b1);
      chk(exp_pkt.size() == 0, "R6 R8 escape after run is packet data", exp_pkt.size(), 0);

      // R9 overrun
      do_arm(24'd2);
      for (int k = 0; k < 5; k++) send_byte(8'h0F, 1'b1);
      busy = 1'b1;
      exp_store.push_back(1'b0); exp_store.push_back(1'b1);
      send_byte(8'h10, 1'b0);
      send_byte(8'h10, 1'b0);
      busy = 1'b0;
      chk(overrun_o == 1'b1, "R9 overrun set", int'(overrun_o), 1);
      chk(done_cnt == 2, "R6 second done", done_cnt, 2);
      send_byte(8'h33, 1'b1);
      chk(overrun_o == 1'b1, "R9 overrun sticky", int'(overrun_o), 1);

      // R1 master run
      set_cookie(8'hAA);
      chk(is_master_o == 1'b1, "R1 cookie AA is master", int'(is_master_o), 1);
      do_arm(24'd4);
      repeat (2) @(negedge clk);
      chk(overrun_o == 1'b0, "R9 arm clears overrun", int'(overrun_o), 0);
      for (int k = 0; k < 5; k++) send_byte(8'h0F, 1'b1);
      for (int k = 0; k < 4; k++) exp_store.push_back(k != 0);
      for (int k = 0; k < 4; k++) begin
         do @(negedge clk); while (!tx_req_o);
         chk(tx_byte_o == 8'h10, "R3 escape byte requested", tx_byte_o, 8'h10);
         send_byte(tx_byte_o, 1'b0);
      end
      repeat (300) @(negedge clk);
      chk(tx_times.size() == 4, "R3 request count equals total", tx_times.size(), 4);
      for (int k = 1; k < tx_times.size(); k++)
         chk(tx_times[k] - tx_times[k-1] == 100, "R3 timer period",
             tx_times[k] - tx_times[k-1], 100);
      chk(sampling_o == 1'b0, "R6 master run ends", int'(sampling_o), 0);
      chk(done_cnt == 3, "R6 master done", done_cnt, 3);
      chk(exp_store.size() == 0, "R4 master sees own trigger", exp_store.size(), 0);
      chk(exp_pkt.size() == 0, "R8 all packet bytes seen", exp_pkt.size(), 0);

      $display("End of test - %0d assertions evaluated, %0d failures",
               checks + mon_checks, fails + mon_fails);
      $finish;
   end
endmodule